// File: doc/BRIEF.md
# Paged Memory Mapper

The mapper widens a 16-bit processor address to a 21-bit physical address. The 64 KB logical space is cut into eight windows of 8 KB. Each window has its own page register, which holds an 8-bit physical page number. The top three logical bits pick a register. Its page number takes the place of those three bits, and the 13-bit offset within the window passes straight through. The result reaches 256 pages of 8 KB, which is 2 MB.

Software loads a page register with a direct write: a strobe, a register index and a page value, all taken on a clock edge. A separate index returns the contents of any register. A lock input protects window 0, whose mapping must not move while it is set. After reset the registers hold pages 0 to 7 in order, so the first 64 KB are mapped one to one. The translation is combinational from the logical address and the registered page table. The mapper adds no pipeline stage to the address path.

Top module: `pager_mmu`

## Requirements
- R1: While `rst` is high at a rising clock edge, page register i is loaded with page number i. After reset, `phys_addr` therefore equals `log_addr` with zeros in bits 20 to 16.
- R2: Bits 15 to 13 of `log_addr` select the page register that supplies the page number for the translation.
- R3: Bits 12 to 0 of `phys_addr` equal bits 12 to 0 of `log_addr` in every cycle.
- R4: Bits 20 to 13 of `phys_addr` hold the 8-bit page number of the selected register, so page 0xFF with offset 0x1FFF gives 0x1FFFFF.
- R5: When `wr_en` is high at a rising edge, the register named by `wr_idx` takes `wr_page`. Translations from the following cycle onward use the new value.
- R6: A translation in the same cycle as a write to its own register uses the value held before that write.
- R7: While `lock_win0` is high, a write to register 0 is ignored. Writes to registers 1 to 7 still take effect.
- R8: While `lock_win0` is low, register 0 accepts writes like any other register.
- R9: `rd_page` returns the current contents of the register named by `rd_idx`, combinationally.
- R10: A write changes only the register it names, and a cycle without a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, loads the identity map |
| log_addr | input | 16 | Logical address to translate |
| phys_addr | output | 21 | Translated physical address |
| wr_en | input | 1 | Page register write strobe |
| wr_idx | input | 3 | Index of the register to write |
| wr_page | input | 8 | Page number to write |
| lock_win0 | input | 1 | When high, writes to register 0 are dropped |
| rd_idx | input | 3 | Index of the register to read |
| rd_page | output | 8 | Contents of the register named by rd_idx |

## Verification
The translation is tried with offsets of all zeros, all ones and mixed bits. This separates the offset passthrough from the page substitution. It also uses addresses on both sides of a window boundary (0x1FFF and 0x2000), which catches a wrong choice of index bits. Writes are presented together with a translation of the same window, so stale use of the old value can be told apart from early use of the new one. Locked and unlocked writes to register 0 are mixed with a locked write to another register. This shows that the lock covers window 0 only. Reads of untouched registers after each write, and a second reset in mid-run, confirm the identity state and that each write reaches only its target.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  // Default geometry: 64 KB logical space, eight 8 KB windows, 256 pages.
  localparam int unsigned MM_LA_W    = 16;
  localparam int unsigned MM_WIN_BITS = 3;
  localparam int unsigned MM_PAGE_W  = 8;

  // Offset width that passes through untranslated.
  function automatic int unsigned ofs_width(input int unsigned la_w,
                                            input int unsigned win_bits);
    return la_w - win_bits;
  endfunction
endpackage

// File: rtl/mmap_page_file.sv
module mmap_page_file #(
  parameter int unsigned WIN_BITS = 3,
  parameter int unsigned PAGE_W   = 8,
  localparam int unsigned NWIN    = 1 << WIN_BITS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [WIN_BITS-1:0]            wr_idx,
  input  logic [PAGE_W-1:0]              wr_page,
  input  logic                           lock_win0,
  output logic [NWIN-1:0][PAGE_W-1:0]    pages_o
);

  logic [NWIN-1:0] hit;

  for (genvar g = 0; g < NWIN; g++) begin : g_slot
    logic [PAGE_W-1:0] slot_q;

    // Window 0 carries the lock qualifier; the others decode the index only.
    if (g == 0) begin : g_locked
      assign hit[g] = wr_en && (wr_idx == WIN_BITS'(g)) && !lock_win0;
    end else begin : g_open
      assign hit[g] = wr_en && (wr_idx == WIN_BITS'(g));
    end

    always_ff @(posedge clk) begin
      if (rst)          slot_q <= PAGE_W'(g);
      else if (hit[g])  slot_q <= wr_page;
    end

    assign pages_o[g] = slot_q;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(lock_win0 && wr_idx == '0)) |=> (pages_o[$past(wr_idx)] == $past(wr_page))); // R5

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lock_win0 && wr_idx == '0) |=> $stable(pages_o)); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pages_o)); // R10

endmodule

// File: rtl/mmap_page_sel.sv
module mmap_page_sel #(
  parameter int unsigned WIN_BITS = 3,
  parameter int unsigned PAGE_W   = 8,
  localparam int unsigned NWIN    = 1 << WIN_BITS
) (
  input  logic [NWIN-1:0][PAGE_W-1:0] pages_i,
  input  logic [WIN_BITS-1:0]         sel_i,
  output logic [PAGE_W-1:0]           page_o
);
  assign page_o = pages_i[sel_i];
endmodule

// File: rtl/pager_mmu.sv
module pager_mmu
  import mmap_pkg::*;
#(
  parameter int unsigned LA_W     = MM_LA_W,
  parameter int unsigned WIN_BITS = MM_WIN_BITS,
  parameter int unsigned PAGE_W   = MM_PAGE_W,
  localparam int unsigned OFS_W   = ofs_width(LA_W, WIN_BITS),
  localparam int unsigned PA_W    = PAGE_W + OFS_W,
  localparam int unsigned NWIN    = 1 << WIN_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LA_W-1:0]     log_addr,
  output logic [PA_W-1:0]     phys_addr,
  input  logic                wr_en,
  input  logic [WIN_BITS-1:0] wr_idx,
  input  logic [PAGE_W-1:0]   wr_page,
  input  logic                lock_win0,
  input  logic [WIN_BITS-1:0] rd_idx,
  output logic [PAGE_W-1:0]   rd_page
);

  logic [NWIN-1:0][PAGE_W-1:0] pages;
  logic [PAGE_W-1:0]           xl_page;
  logic [WIN_BITS-1:0]         win_sel;

  assign win_sel = log_addr[LA_W-1 -: WIN_BITS];

  mmap_page_file #(.WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W)) i_file (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_page   (wr_page),
    .lock_win0 (lock_win0),
    .pages_o   (pages)
  );

  // Address path: window index picks the page.
  mmap_page_sel #(.WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W)) i_xl_sel (
    .pages_i (pages),
    .sel_i   (win_sel),
    .page_o  (xl_page)
  );

  // Software read path.
  mmap_page_sel #(.WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W)) i_rd_sel (
    .pages_i (pages),
    .sel_i   (rd_idx),
    .page_o  (rd_page)
  );

  assign phys_addr = {xl_page, log_addr[OFS_W-1:0]};

  AST_READ_AGREES: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == win_sel) |-> (rd_page == phys_addr[PA_W-1 -: PAGE_W])); // R9

endmodule

// File: tb/test_pager_mmu.sv
`timescale 1ns/1ps
module test_pager_mmu;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] log_addr;
  logic [20:0] phys_addr;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [7:0]  wr_page;
  logic        lock_win0;
  logic [2:0]  rd_idx;
  logic [7:0]  rd_page;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pager_mmu i_pager_mmu (
    .clk(clk), .rst(rst), .log_addr(log_addr), .phys_addr(phys_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_page(wr_page), .lock_win0(lock_win0),
    .rd_idx(rd_idx), .rd_page(rd_page)
  );

  // Fields: req(8) wr(1) lock(1) idx(3) page(8) addr(16) expected phys(21)
  localparam int VW = 58;
  localparam int NV = 14;
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'd1, 1'b0, 1'b0, 3'd0, 8'h00, 16'hE5A7, 21'h00E5A7}, // R1 identity, window 7
    {8'd6, 1'b1, 1'b0, 3'd3, 8'hC4, 16'h6001, 21'h006001}, // R6 old value same cycle
    {8'd5, 1'b0, 1'b0, 3'd0, 8'h00, 16'h6001, 21'h188001}, // R5 new page visible
    {8'd3, 1'b0, 1'b0, 3'd0, 8'h00, 16'h7FFF, 21'h189FFF}, // R3 offset all ones
    {8'd7, 1'b1, 1'b1, 3'd0, 8'h55, 16'h0ABC, 21'h000ABC}, // R7 locked write
    {8'd7, 1'b0, 1'b0, 3'd0, 8'h00, 16'h0ABC, 21'h000ABC}, // R7 window 0 kept
    {8'd7, 1'b1, 1'b1, 3'd5, 8'hFF, 16'hA000, 21'h00A000}, // R7 other reg under lock
    {8'd4, 1'b0, 1'b0, 3'd0, 8'h00, 16'hBFFF, 21'h1FFFFF}, // R4 top of 2 MB
    {8'd8, 1'b1, 1'b0, 3'd0, 8'h55, 16'h0000, 21'h000000}, // R8 unlocked write
    {8'd8, 1'b0, 1'b0, 3'd0, 8'h00, 16'h1FFF, 21'h0ABFFF}, // R8 window 0 moved
    {8'd2, 1'b0, 1'b0, 3'd0, 8'h00, 16'h2000, 21'h002000}, // R2 boundary, window 1
    {8'd2, 1'b0, 1'b0, 3'd0, 8'h00, 16'h8123, 21'h008123}, // R2 window 4
    {8'd10,1'b1, 1'b0, 3'd3, 8'h00, 16'h4000, 21'h004000}, // R10 write reg3, look at reg2
    {8'd5, 1'b0, 1'b0, 3'd0, 8'h00, 16'h6ABC, 21'h000ABC}  // R5 overwrite to page 0
  };

  task automatic chk_phys(input int req, input logic [20:0] exp);
    checks++;
    if (phys_addr !== exp) begin
      errors++;
      $display("FAIL R%0d phys_addr actual %06h expected %06h", req, phys_addr, exp);
    end
  endtask

  task automatic chk_read(input int req, input logic [2:0] idx, input logic [7:0] exp);
    rd_idx = idx;
    #0.5;
    checks++;
    if (rd_page !== exp) begin
      errors++;
      $display("FAIL R%0d rd_page[%0d] actual %02h expected %02h", req, idx, rd_page, exp);
    end
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_page = '0; lock_win0 = 1'b0;
    log_addr = '0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state through the read port
    for (int i = 0; i < 8; i++) chk_read(1, 3'(i), 8'(i));

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en     = VEC[v][49];
      lock_win0 = VEC[v][48];
      wr_idx    = VEC[v][47:45];
      wr_page   = VEC[v][44:37];
      log_addr  = VEC[v][36:21];
      #1;
      chk_phys(int'(VEC[v][57:50]), VEC[v][20:0]);
      @(posedge clk);
    end
    @(negedge clk);
    wr_en = 1'b0; lock_win0 = 1'b0;

    // R9 read port after the table's writes
    chk_read(9, 3'd0, 8'h55);
    chk_read(9, 3'd3, 8'h00);
    chk_read(9, 3'd5, 8'hFF);
    // R10 untouched registers keep their reset pages
    chk_read(10, 3'd1, 8'h01);
    chk_read(10, 3'd2, 8'h02);
    chk_read(10, 3'd4, 8'h04);
    chk_read(10, 3'd6, 8'h06);
    chk_read(10, 3'd7, 8'h07);

    // R1 second reset restores the identity map
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 8; i++) chk_read(1, 3'(i), 8'(i));
    log_addr = 16'hBFFF;
    #0.5 chk_phys(1, 21'h00BFFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule